// File: doc/BRIEF.md
# Low flag byte transfer unit

This block holds the arithmetic status flags (sign, zero, auxiliary carry, parity, carry) together with a direction flag. It executes one flag instruction per clock, chosen by an opcode strobed with a valid bit. The instructions are:

- move the flags to or from an 8-bit byte with a fixed layout;
- clear, set or complement carry;
- produce an all-ones or all-zeros byte from carry;
- clear or set direction.

Each accepted instruction produces a registered result byte and a one-cycle result-valid pulse on the following clock edge. The current flag values are always visible on dedicated outputs.

How the flags are produced by arithmetic and how instructions are decoded lie outside the block. The surrounding pipeline presents an already-decoded opcode and, when loading, the source byte.

Top module: `lowflag_xfer`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, all six flags, `res_valid_o` and `res_byte_o` become 0.
- R2: Opcode 0 (load) sets the five flags from `byte_i` on the next edge, using bit positions sign=7, zero=6, aux=4, parity=2, carry=0. Bits 5, 3 and 1 of `byte_i` are ignored, and direction keeps its value.
- R3: Opcode 1 (store) makes `res_byte_o` hold the flags as they were before the edge, in the R2 positions. Bit 1 of the byte is 1, and bits 5 and 3 are 0.
- R4: Opcode 2 clears carry and opcode 3 sets carry. All other flags keep their values.
- R5: Opcode 4 inverts carry. All other flags keep their values.
- R6: Opcode 5 (fill) makes `res_byte_o` 0xFF when carry was 1 and 0x00 when carry was 0, and leaves every flag unchanged.
- R7: Opcode 6 clears direction and opcode 7 sets direction. The five arithmetic flags keep their values.
- R8: `res_valid_o` is 1 for exactly the cycle after each accepted opcode 0 to 7. For opcodes other than 1 and 5, `res_byte_o` is 0x00 in that cycle.
- R9: When `op_valid_i` is low, or the opcode is 8 to 15, no flag changes and `res_valid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid_i | input | 1 | Opcode strobe |
| op_i | input | 4 | Flag instruction opcode |
| byte_i | input | 8 | Source byte for load |
| sign_o | output | 1 | Sign flag |
| zero_o | output | 1 | Zero flag |
| aux_o | output | 1 | Auxiliary carry flag |
| parity_o | output | 1 | Parity flag |
| carry_o | output | 1 | Carry flag |
| dir_o | output | 1 | Direction flag |
| res_byte_o | output | 8 | Result byte |
| res_valid_o | output | 1 | One-cycle result strobe |

## Verification
The assertions assume that `op_valid_i`, `op_i` and `byte_i` are stable around each rising edge. They also assume that inputs present during a reset cycle carry no meaning, which is why every property tests that reset was high in the previous cycle. The bench changes inputs only on falling edges and holds `op_valid_i` low during reset and between operations. The one exception is the deliberate strobe with an undefined opcode, which checks that such input is ignored.

// File: rtl/lfx_pkg.sv
// Package for the low flag byte transfer unit.
// Holds the opcode encoding, the byte-image bit positions and the helpers
// that convert between the flag record and its byte image.
// Assumes an 8-bit image; the positions below are fixed by behaviour.
package lfx_pkg;
    localparam int BYTE_W  = 8;
    localparam int OP_W    = 4;
    localparam int NUM_OPS = 8;

    localparam int POS_SGN = 7;
    localparam int POS_ZRO = 6;
    localparam int POS_AUX = 4;
    localparam int POS_PAR = 2;
    localparam int POS_ONE = 1;
    localparam int POS_CRY = 0;

    localparam int OPI_LOAD  = 0;
    localparam int OPI_STORE = 1;
    localparam int OPI_CLRC  = 2;
    localparam int OPI_SETC  = 3;
    localparam int OPI_CMPC  = 4;
    localparam int OPI_FILL  = 5;
    localparam int OPI_CLRD  = 6;
    localparam int OPI_SETD  = 7;

    typedef struct packed {
        logic dir;
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } lfx_flags_t;

    // Build the byte image from the flags; the constant bit is forced high.
    function automatic logic [BYTE_W-1:0] image_of(input lfx_flags_t f);
        logic [BYTE_W-1:0] b;
        b          = '0;
        b[POS_SGN] = f.sgn;
        b[POS_ZRO] = f.zro;
        b[POS_AUX] = f.aux;
        b[POS_PAR] = f.par;
        b[POS_ONE] = 1'b1;
        b[POS_CRY] = f.cry;
        return b;
    endfunction

    // Take the five arithmetic flags from a byte; direction comes from old.
    function automatic lfx_flags_t flags_of(input logic [BYTE_W-1:0] b,
                                             input lfx_flags_t old);
        lfx_flags_t f;
        f     = old;
        f.sgn = b[POS_SGN];
        f.zro = b[POS_ZRO];
        f.aux = b[POS_AUX];
        f.par = b[POS_PAR];
        f.cry = b[POS_CRY];
        return f;
    endfunction
endpackage

// File: rtl/lfx_decode.sv
// Opcode decoder for the low flag byte transfer unit.
// Turns a strobed opcode into a one-hot hit vector, one line per defined
// operation. Undefined opcodes and an idle strobe give an all-zero vector.
// Assumes the opcode is stable while the strobe is sampled.
module lfx_decode
    import lfx_pkg::*;
(
    input  logic               op_valid_i,
    input  logic [OP_W-1:0]    op_i,
    output logic [NUM_OPS-1:0] hit_o
);
    // One comparator per defined operation.
    for (genvar k = 0; k < NUM_OPS; k++) begin : g_hit
        assign hit_o[k] = op_valid_i && (op_i == OP_W'(k));
    end
endmodule

// File: rtl/lfx_flag_reg.sv
// Flag state register for the low flag byte transfer unit.
// Computes the next flag record from the one-hot hit vector and registers
// it. Flags move only on an edge where a hit is present.
// Assumes hit_i is one-hot or zero (guaranteed by lfx_decode).
module lfx_flag_reg
    import lfx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OPS-1:0] hit_i,
    input  logic [BYTE_W-1:0]  byte_i,
    output lfx_flags_t         flags_o
);
    lfx_flags_t nxt;

    // Select the next flag record for the operation in flight.
    always_comb begin
        nxt = flags_o;
        if (hit_i[OPI_LOAD]) nxt = flags_of(byte_i, flags_o);
        if (hit_i[OPI_CLRC]) nxt.cry = 1'b0;
        if (hit_i[OPI_SETC]) nxt.cry = 1'b1;
        if (hit_i[OPI_CMPC]) nxt.cry = ~flags_o.cry;
        if (hit_i[OPI_CLRD]) nxt.dir = 1'b0;
        if (hit_i[OPI_SETD]) nxt.dir = 1'b1;
    end

    // Hold the flags; synchronous reset clears them all.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_o <= '0;
        else        flags_o <= nxt;
    end

    // R2
    load_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(hit_i[OPI_LOAD]) |->
        {flags_o.sgn, flags_o.zro, flags_o.aux, flags_o.par, flags_o.cry} ==
        {$past(byte_i[POS_SGN]), $past(byte_i[POS_ZRO]), $past(byte_i[POS_AUX]),
         $past(byte_i[POS_PAR]), $past(byte_i[POS_CRY])} &&
        $stable(flags_o.dir));

    // R4
    clear_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(hit_i[OPI_CLRC]) |-> !flags_o.cry);

    // R4
    set_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(hit_i[OPI_SETC]) |-> flags_o.cry);

    // R5
    flip_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(hit_i[OPI_CMPC]) |->
        flags_o.cry != $past(flags_o.cry) && $stable(flags_o.sgn));

    // R6
    fill_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(hit_i[OPI_FILL]) |-> $stable(flags_o));

    // R7
    dir_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(hit_i[OPI_CLRD]) |-> !flags_o.dir && $stable(flags_o.cry));

    // R7
    dir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(hit_i[OPI_SETD]) |-> flags_o.dir && $stable(flags_o.cry));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(hit_i) == '0) |-> $stable(flags_o));
endmodule

// File: rtl/lfx_byte_out.sv
// Result byte stage for the low flag byte transfer unit.
// Registers the byte produced by store or fill (zero for other operations)
// and raises the result strobe for one cycle after any accepted operation.
// Assumes flags_i are the flags before the edge that retires the operation.
module lfx_byte_out
    import lfx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OPS-1:0] hit_i,
    input  lfx_flags_t         flags_i,
    output logic [BYTE_W-1:0]  res_byte_o,
    output logic               res_valid_o
);
    logic [BYTE_W-1:0] nxt_byte;

    // Pick the result byte for the operation in flight.
    always_comb begin
        nxt_byte = '0;
        if (hit_i[OPI_STORE]) nxt_byte = image_of(flags_i);
        if (hit_i[OPI_FILL])  nxt_byte = {BYTE_W{flags_i.cry}};
    end

    // Register the byte and the strobe; reset clears both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_byte_o  <= '0;
            res_valid_o <= 1'b0;
        end else begin
            res_byte_o  <= nxt_byte;
            res_valid_o <= |hit_i;
        end
    end

    // R3
    store_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(hit_i[OPI_STORE]) |->
        res_byte_o[POS_ONE] && !res_byte_o[5] && !res_byte_o[3] &&
        res_byte_o[POS_CRY] == $past(flags_i.cry) && res_byte_o[POS_SGN] == $past(flags_i.sgn));

    // R6
    fill_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(hit_i[OPI_FILL]) |->
        res_byte_o == {BYTE_W{$past(flags_i.cry)}});

    // R8
    strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> res_valid_o == ($past(hit_i) != '0));

    // R8
    quiet_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(hit_i[OPI_STORE]) && !$past(hit_i[OPI_FILL]) |->
        res_byte_o == '0);
endmodule

// File: rtl/lowflag_xfer.sv
// Low flag byte transfer unit, top level.
// Decodes a strobed opcode, updates the flag register and produces the
// result byte and strobe. One operation retires per clock.
// Assumes inputs change away from the rising edge and carry no meaning
// while reset is asserted.
module lowflag_xfer
    import lfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              sign_o,
    output logic              zero_o,
    output logic              aux_o,
    output logic              parity_o,
    output logic              carry_o,
    output logic              dir_o,
    output logic [BYTE_W-1:0] res_byte_o,
    output logic              res_valid_o
);
    logic [NUM_OPS-1:0] hit;
    lfx_flags_t         flags;

    lfx_decode u_decode (
        .op_valid_i (op_valid_i),
        .op_i       (op_i),
        .hit_o      (hit)
    );

    lfx_flag_reg u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (hit),
        .byte_i  (byte_i),
        .flags_o (flags)
    );

    lfx_byte_out u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_i       (hit),
        .flags_i     (flags),
        .res_byte_o  (res_byte_o),
        .res_valid_o (res_valid_o)
    );

    // Expose the flag record on individual pins.
    always_comb begin
        sign_o   = flags.sgn;
        zero_o   = flags.zro;
        aux_o    = flags.aux;
        parity_o = flags.par;
        carry_o  = flags.cry;
        dir_o    = flags.dir;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst_n) == 1'b0 && $past(rst_n, 2) == 1'b0 |->
        !res_valid_o && res_byte_o == '0 && !carry_o && !dir_o);
endmodule

// File: tb/lowflag_xfer_bench.sv
module lowflag_xfer_bench;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid_i = 1'b0;
    logic [3:0] op_i = 4'd0;
    logic [7:0] byte_i = 8'd0;
    logic       sign_o, zero_o, aux_o, parity_o, carry_o, dir_o;
    logic [7:0] res_byte_o;
    logic       res_valid_o;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lowflag_xfer u_lowflag_xfer (
        .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_i(op_i),
        .byte_i(byte_i), .sign_o(sign_o), .zero_o(zero_o), .aux_o(aux_o),
        .parity_o(parity_o), .carry_o(carry_o), .dir_o(dir_o),
        .res_byte_o(res_byte_o), .res_valid_o(res_valid_o)
    );

    // Flags packed as {dir, sign, zero, aux, parity, carry}.
    function automatic logic [7:0] fl();
        return {2'b00, dir_o, sign_o, zero_o, aux_o, parity_o, carry_o};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Present one operation on a falling edge; return at the next falling edge.
    task automatic run_op(input logic [3:0] op, input logic [7:0] b, input logic vld = 1'b1);
        @(negedge clk);
        op_valid_i = vld; op_i = op; byte_i = b;
        @(negedge clk);
        op_valid_i = 1'b0; byte_i = 8'h00;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 flags", fl(), 8'h00);
        chk("R1 valid", {7'd0, res_valid_o}, 8'h00);
        chk("R1 byte", res_byte_o, 8'h00);
        rst_n = 1'b1;
    endtask

    task automatic t_store_load();
        run_op(4'd1, 8'h00);
        chk("R3 store after reset", res_byte_o, 8'h02);
        chk("R8 valid pulse", {7'd0, res_valid_o}, 8'h01);
        @(negedge clk);
        chk("R8 pulse one cycle", {7'd0, res_valid_o}, 8'h00);
        run_op(4'd0, 8'hFF);
        chk("R2 load ff", fl(), 8'h1F);
        chk("R8 load byte zero", res_byte_o, 8'h00);
        run_op(4'd1, 8'h00);
        chk("R3 store all set", res_byte_o, 8'hD7);
        run_op(4'd0, 8'h2A);
        chk("R2 ignored bits", fl(), 8'h00);
        run_op(4'd0, 8'h85);
        chk("R2 load 85", fl(), 8'h13);
        run_op(4'd1, 8'h00);
        chk("R3 store 85", res_byte_o, 8'h87);
    endtask

    task automatic t_carry();
        run_op(4'd0, 8'h50);
        run_op(4'd3, 8'h00);
        chk("R4 set carry", fl(), 8'h0D);
        run_op(4'd2, 8'h00);
        chk("R4 clear carry", fl(), 8'h0C);
        chk("R8 clear byte zero", res_byte_o, 8'h00);
        run_op(4'd4, 8'h00);
        chk("R5 complement to 1", fl(), 8'h0D);
        run_op(4'd4, 8'h00);
        chk("R5 complement to 0", fl(), 8'h0C);
    endtask

    task automatic t_fill();
        run_op(4'd3, 8'h00);
        run_op(4'd5, 8'h00);
        chk("R6 fill ones", res_byte_o, 8'hFF);
        chk("R6 flags kept", fl(), 8'h0D);
        run_op(4'd2, 8'h00);
        run_op(4'd5, 8'h00);
        chk("R6 fill zeros", res_byte_o, 8'h00);
        chk("R6 valid", {7'd0, res_valid_o}, 8'h01);
    endtask

    task automatic t_dir();
        run_op(4'd7, 8'h00);
        chk("R7 set dir", fl(), 8'h2C);
        run_op(4'd0, 8'h01);
        chk("R2 dir kept on load", fl(), 8'h21);
        run_op(4'd6, 8'h00);
        chk("R7 clear dir", fl(), 8'h01);
    endtask

    task automatic t_ignore();
        run_op(4'd9, 8'hFF);
        chk("R9 undefined flags", fl(), 8'h01);
        chk("R9 undefined no valid", {7'd0, res_valid_o}, 8'h00);
        run_op(4'd0, 8'hD4, 1'b0);
        chk("R9 idle strobe flags", fl(), 8'h01);
        chk("R9 idle no valid", {7'd0, res_valid_o}, 8'h00);
        run_op(4'd15, 8'h00);
        run_op(4'd1, 8'h00);
        chk("R9 state via store", res_byte_o, 8'h03);
    endtask

    initial begin
        t_reset();
        t_store_load();
        t_carry();
        t_fill();
        t_dir();
        t_ignore();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule